// File: doc/BRIEF.md
# Shader Condition Code Branch Unit

This block is the flow-control unit of a four-lane vector shader core. It owns the program counter, a four-component condition code register and a four-entry return-address stack. The arithmetic unit sits outside this block. Each cycle it presents at most one executing instruction. For that instruction it supplies the result vector (four single-precision floats), a flag that asks for a condition code update, and the flow-control fields: operation kind, condition test, condition swizzle, destination write mask and branch target.

The unit classifies each result component into one of four condition states. It tests the stored states through a swizzle to decide whether a branch, call or return is taken, and it produces a per-lane conditional write mask for the destination. Targets come either from the instruction or from one component of an address register vector. A program begins on `start`. It ends when a return finds the stack empty, or when the executed-instruction budget runs out.

Top module: `ccbu_top`

## Requirements
- R1: After reset, `pc` is 0, `running` is 0, `ovfErr` and `limitErr` are 0, and every condition component holds EQ. The condition code encoding is LT=0, EQ=1, GT=2, UN=3. Component i of `ccOut` sits at bits [2i+1:2i].
- R2: `start` sets `pc` to 0 and `running` to 1, clears both error flags and the executed count, empties the return stack and sets every condition component to EQ. It has priority over an instruction presented in the same cycle.
- R3: An executed instruction with `ccUpdate`=1 loads component i of the condition register at the next edge, from float i of `resVec` (bits [32i+31:32i]). A NaN (exponent all ones, mantissa nonzero) gives UN. Either signed zero gives EQ. Any other negative value gives LT, and any other positive value gives GT, infinities included.
- R4: An executed instruction with `ccUpdate`=0 leaves the condition register unchanged.
- R5: The `ccTest` encodings are FL=0, GT=1, EQ=2, GE=3, LT=4, NE=5, LE=6, TR=7. A UN component passes only NE and TR.
- R6: Lane i of the test uses condition component `ccSwz[2i+1:2i]`. An instruction's condition holds if any lane passes. `opKind` is NOP=0, BRA=1, CAL=2, RET=3. A BRA whose condition holds loads the target; otherwise `pc` advances by one. The target is `tgtAddr`, or, when `useIndirect`=1, component `addrSel` of `addrVec` (bits [8k+7:8k]).
- R7: A CAL whose condition holds pushes `pc`+1 and jumps to the target. A RET whose condition holds pops the newest stored address into `pc`. Up to four addresses nest.
- R8: A taken CAL with four addresses already stored sets `ovfErr`, pushes nothing and advances `pc` by one. Execution continues.
- R9: A taken RET with an empty stack clears `running` and leaves `pc` unchanged.
- R10: `condMask` lane i equals `writeMask` bit i AND the result of the test on lane i, using the current condition register. It is combinational.
- R11: When the 65536th instruction since `start` executes, `running` clears and `limitErr` sets, after that instruction's own effect.
- R12: While `running` is 0, presented instructions change neither `pc` nor the condition register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a program at address 0 |
| instValid | input | 1 | An instruction executes this cycle |
| opKind | input | 2 | NOP, BRA, CAL, RET |
| ccUpdate | input | 1 | Load condition codes from this result |
| resVec | input | 128 | Four fp32 result components |
| ccSwz | input | 8 | Condition component selected per lane |
| ccTest | input | 3 | Condition test |
| writeMask | input | 4 | Instruction destination write mask |
| useIndirect | input | 1 | Take the target from the address register |
| tgtAddr | input | 8 | Direct target |
| addrVec | input | 32 | Address register, four 8-bit components |
| addrSel | input | 2 | Address register component for indirect targets |
| pc | output | 8 | Program counter |
| running | output | 1 | Program active |
| ccOut | output | 8 | Condition register contents |
| condMask | output | 4 | Conditional write mask |
| ovfErr | output | 1 | Call stack overflow seen |
| limitErr | output | 1 | Execution budget exhausted |

## Verification
A single instruction can both request a condition update and branch or mask on the condition register. The bench issues such instructions with a result that flips the test outcome. The model then requires the branch and the mask to follow the codes stored before the edge, with the new codes visible only one cycle later. A second collision is the fifth nested call, where the overflow flag must rise while the program counter only advances. The bench also checks that the stack stays intact so that the later four returns unwind to the correct addresses.

// File: rtl/ccbu_pkg.sv
package ccbu_pkg;

  typedef enum logic [1:0] {CC_LT = 2'd0, CC_EQ = 2'd1, CC_GT = 2'd2, CC_UN = 2'd3} ccCode_t;
  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_BRA = 2'd1, OP_CAL = 2'd2, OP_RET = 2'd3} opKind_t;
  typedef enum logic [2:0] {
    T_FL = 3'd0, T_GT = 3'd1, T_EQ = 3'd2, T_GE = 3'd3,
    T_LT = 3'd4, T_NE = 3'd5, T_LE = 3'd6, T_TR = 3'd7
  } ccTest_t;
  typedef enum logic [1:0] {PC_INC = 2'd0, PC_TGT = 2'd1, PC_POP = 2'd2, PC_HOLD = 2'd3} pcSel_t;

  typedef struct packed {
    logic   clear;
    logic   ccWr;
    logic   push;
    pcSel_t pcSel;
  } dpCtl_t;

  function automatic logic testPass(ccTest_t t, ccCode_t c);
    case (t)
      T_FL:    return 1'b0;
      T_GT:    return c == CC_GT;
      T_EQ:    return c == CC_EQ;
      T_GE:    return (c == CC_GT) || (c == CC_EQ);
      T_LT:    return c == CC_LT;
      T_NE:    return c != CC_EQ;
      T_LE:    return (c == CC_LT) || (c == CC_EQ);
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ccbu_datapath.sv
module ccbu_datapath
  import ccbu_pkg::*;
#(
  parameter int PC_W        = 8,
  parameter int NUM_COMP    = 4,
  parameter int STACK_DEPTH = 4,
  parameter int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtl_t                       ctl,
  input  logic [DEPTH_W-1:0]           depth,
  input  logic [32*NUM_COMP-1:0]       resVec,
  input  logic [2*NUM_COMP-1:0]        ccSwz,
  input  ccTest_t                      ccTest,
  input  logic [NUM_COMP-1:0]          writeMask,
  input  logic                         useIndirect,
  input  logic [PC_W-1:0]              tgtAddr,
  input  logic [PC_W*NUM_COMP-1:0]     addrVec,
  input  logic [$clog2(NUM_COMP)-1:0]  addrSel,
  output logic [PC_W-1:0]              pc,
  output logic [2*NUM_COMP-1:0]        ccOut,
  output logic                         anyPass,
  output logic [NUM_COMP-1:0]          condMask
);
  localparam int SEL_W = $clog2(NUM_COMP);
  localparam int IDX_W = $clog2(STACK_DEPTH);

  ccCode_t             ccReg   [NUM_COMP];
  ccCode_t             ccNext  [NUM_COMP];
  logic [NUM_COMP-1:0] lanePass;
  logic [PC_W-1:0]     retStack [STACK_DEPTH];
  logic [PC_W-1:0]     target;
  logic [PC_W-1:0]     pcInc;
  logic [DEPTH_W-1:0]  topSlot;

  for (genvar i = 0; i < NUM_COMP; i++) begin : g_comp
    logic [31:0]      fVal;
    logic [SEL_W-1:0] swz;
    assign fVal = resVec[32*i +: 32];
    assign swz  = ccSwz[SEL_W*i +: SEL_W];

    always_comb begin
      if (fVal[30:23] == 8'hFF && fVal[22:0] != '0) ccNext[i] = CC_UN;
      else if (fVal[30:0] == '0)                    ccNext[i] = CC_EQ;
      else if (fVal[31])                            ccNext[i] = CC_LT;
      else                                          ccNext[i] = CC_GT;
    end

    assign lanePass[i]     = testPass(ccTest, ccReg[swz]);
    assign ccOut[2*i +: 2] = ccReg[i];

    always_ff @(posedge clk) begin
      if (!rstN || ctl.clear) ccReg[i] <= CC_EQ;
      else if (ctl.ccWr)      ccReg[i] <= ccNext[i];
    end
  end

  assign anyPass  = |lanePass;
  assign condMask = writeMask & lanePass;
  assign target   = useIndirect ? addrVec[PC_W*addrSel +: PC_W] : tgtAddr;
  assign pcInc    = pc + PC_W'(1);
  assign topSlot  = depth - DEPTH_W'(1);

  always_ff @(posedge clk) begin
    if (ctl.push) retStack[depth[IDX_W-1:0]] <= pcInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) pc <= '0;
    else begin
      case (ctl.pcSel)
        PC_INC:  pc <= pcInc;
        PC_TGT:  pc <= target;
        PC_POP:  pc <= retStack[topSlot[IDX_W-1:0]];
        default: pc <= pc;
      endcase
    end
  end

  // R4: codes move only on an update strobe or a clear
  p_cc_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.ccWr && !ctl.clear) |=> $stable(ccOut));

  // R12: a hold request keeps the program counter
  p_pc_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcSel == PC_HOLD && !ctl.clear) |=> $stable(pc));

endmodule

// File: rtl/ccbu_control.sv
module ccbu_control
  import ccbu_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int MAX_EXEC    = 65536,
  parameter int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               instValid,
  input  opKind_t            opKind,
  input  logic               ccUpdate,
  input  logic               anyPass,
  output dpCtl_t             ctl,
  output logic [DEPTH_W-1:0] depth,
  output logic               running,
  output logic               ovfErr,
  output logic               limitErr
);
  localparam int CNT_W = $clog2(MAX_EXEC + 1);

  logic             exec;
  logic             stackFull;
  logic             callOvf;
  logic             retEmpty;
  logic             budgetEnd;
  logic [CNT_W-1:0] execCnt;

  assign exec      = running && instValid && !start;
  assign stackFull = depth == DEPTH_W'(STACK_DEPTH);
  assign callOvf   = exec && anyPass && opKind == OP_CAL && stackFull;
  assign retEmpty  = exec && anyPass && opKind == OP_RET && depth == '0;
  assign budgetEnd = exec && execCnt == CNT_W'(MAX_EXEC - 1);

  always_comb begin
    ctl.clear = start;
    ctl.ccWr  = exec && ccUpdate;
    ctl.push  = 1'b0;
    ctl.pcSel = exec ? PC_INC : PC_HOLD;
    if (exec && anyPass) begin
      case (opKind)
        OP_BRA: ctl.pcSel = PC_TGT;
        OP_CAL: if (!stackFull) begin
                  ctl.push  = 1'b1;
                  ctl.pcSel = PC_TGT;
                end
        OP_RET: ctl.pcSel = (depth == '0) ? PC_HOLD : PC_POP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      depth    <= '0;
      ovfErr   <= 1'b0;
      limitErr <= 1'b0;
      execCnt  <= '0;
    end else if (start) begin
      running  <= 1'b1;
      depth    <= '0;
      ovfErr   <= 1'b0;
      limitErr <= 1'b0;
      execCnt  <= '0;
    end else if (exec) begin
      execCnt <= execCnt + CNT_W'(1);
      if (ctl.push)                  depth <= depth + DEPTH_W'(1);
      else if (ctl.pcSel == PC_POP)  depth <= depth - DEPTH_W'(1);
      if (callOvf)   ovfErr   <= 1'b1;
      if (budgetEnd) limitErr <= 1'b1;
      if (retEmpty || budgetEnd) running <= 1'b0;
    end
  end

  // R7: nesting never exceeds the stack
  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(STACK_DEPTH));

  // R9: a taken return on an empty stack ends the program
  p_ret_empty_halt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && instValid && !start && anyPass && opKind == OP_RET && depth == '0) |=> !running);

  // R11: an exhausted budget leaves the unit stopped
  p_limit_halt_r11: assert property (@(posedge clk) disable iff (!rstN)
    (limitErr && !start) |-> !running);

  // R12: an idle unit stays idle without start
  p_idle_ignore_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !start) |=> (!running && $stable(depth)));

endmodule

// File: rtl/ccbu_top.sv
module ccbu_top
  import ccbu_pkg::*;
#(
  parameter int PC_W        = 8,
  parameter int NUM_COMP    = 4,
  parameter int STACK_DEPTH = 4,
  parameter int MAX_EXEC    = 65536
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic                         instValid,
  input  logic [1:0]                   opKind,
  input  logic                         ccUpdate,
  input  logic [32*NUM_COMP-1:0]       resVec,
  input  logic [2*NUM_COMP-1:0]        ccSwz,
  input  logic [2:0]                   ccTest,
  input  logic [NUM_COMP-1:0]          writeMask,
  input  logic                         useIndirect,
  input  logic [PC_W-1:0]              tgtAddr,
  input  logic [PC_W*NUM_COMP-1:0]     addrVec,
  input  logic [$clog2(NUM_COMP)-1:0]  addrSel,
  output logic [PC_W-1:0]              pc,
  output logic                         running,
  output logic [2*NUM_COMP-1:0]        ccOut,
  output logic [NUM_COMP-1:0]          condMask,
  output logic                         ovfErr,
  output logic                         limitErr
);
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);

  dpCtl_t             ctl;
  logic [DEPTH_W-1:0] depth;
  logic               anyPass;

  ccbu_control #(
    .STACK_DEPTH(STACK_DEPTH), .MAX_EXEC(MAX_EXEC), .DEPTH_W(DEPTH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .instValid(instValid),
    .opKind(opKind_t'(opKind)), .ccUpdate(ccUpdate), .anyPass(anyPass),
    .ctl(ctl), .depth(depth), .running(running), .ovfErr(ovfErr), .limitErr(limitErr)
  );

  ccbu_datapath #(
    .PC_W(PC_W), .NUM_COMP(NUM_COMP), .STACK_DEPTH(STACK_DEPTH), .DEPTH_W(DEPTH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .depth(depth), .resVec(resVec),
    .ccSwz(ccSwz), .ccTest(ccTest_t'(ccTest)), .writeMask(writeMask),
    .useIndirect(useIndirect), .tgtAddr(tgtAddr), .addrVec(addrVec), .addrSel(addrSel),
    .pc(pc), .ccOut(ccOut), .anyPass(anyPass), .condMask(condMask)
  );

  // R8: an overflowing call only steps the program counter
  p_ovf_no_branch_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfErr) |-> pc == PC_W'($past(pc) + 1));

endmodule

// File: tb/ccbu_top_test.sv
`timescale 1ns/1ps
module ccbu_top_test;
  logic         clk = 1'b0;
  logic         rstN, start, instValid, ccUpdate, useIndirect;
  logic [1:0]   opKind, addrSel;
  logic [127:0] resVec;
  logic [7:0]   ccSwz, tgtAddr;
  logic [2:0]   ccTest;
  logic [3:0]   writeMask;
  logic [31:0]  addrVec;
  logic [7:0]   pc, ccOut;
  logic         running, ovfErr, limitErr;
  logic [3:0]   condMask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int mPc, mRun, mOvf, mLim, mCnt;
  int mCc[4];
  int mStack[$];

  always #4 clk = ~clk;

  ccbu_top uut (
    .clk(clk), .rstN(rstN), .start(start), .instValid(instValid), .opKind(opKind),
    .ccUpdate(ccUpdate), .resVec(resVec), .ccSwz(ccSwz), .ccTest(ccTest),
    .writeMask(writeMask), .useIndirect(useIndirect), .tgtAddr(tgtAddr),
    .addrVec(addrVec), .addrSel(addrSel), .pc(pc), .running(running), .ccOut(ccOut),
    .condMask(condMask), .ovfErr(ovfErr), .limitErr(limitErr)
  );

  function automatic int classify(logic [31:0] f);
    logic [31:0] mag = f & 32'h7FFF_FFFF;
    if (mag > 32'h7F80_0000) return 3;
    if (mag == 0) return 1;
    return f[31] ? 0 : 2;
  endfunction

  function automatic bit passes(int t, int c);
    bit lt = (c == 0), eq = (c == 1), gt = (c == 2);
    case (t)
      0: return 0;
      1: return gt;
      2: return eq;
      3: return gt || eq;
      4: return lt;
      5: return !eq;
      6: return lt || eq;
      default: return 1;
    endcase
  endfunction

  function automatic int expMask();
    int m = 0;
    for (int i = 0; i < 4; i++)
      if (writeMask[i] && passes(int'(ccTest), mCc[ccSwz[2*i +: 2]])) m |= (1 << i);
    return m;
  endfunction

  function automatic int expCc();
    int v = 0;
    for (int i = 0; i < 4; i++) v |= (mCc[i] << (2 * i));
    return v;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkState(string tag);
    chk(tag, "pc", int'(pc), mPc);
    chk(tag, "running", int'(running), mRun);
    chk(tag, "ccOut", int'(ccOut), expCc());
    chk(tag, "ovfErr", int'(ovfErr), mOvf);
    chk(tag, "limitErr", int'(limitErr), mLim);
  endtask

  task automatic modelEdge();
    bit any = 0;
    int nPc, tgt;
    bit halt = 0;
    if (!rstN) begin
      mPc = 0; mRun = 0; mOvf = 0; mLim = 0; mCnt = 0;
      for (int i = 0; i < 4; i++) mCc[i] = 1;
      mStack.delete();
    end else if (start) begin
      mPc = 0; mRun = 1; mOvf = 0; mLim = 0; mCnt = 0;
      for (int i = 0; i < 4; i++) mCc[i] = 1;
      mStack.delete();
    end else if (mRun != 0 && instValid) begin
      for (int i = 0; i < 4; i++)
        if (passes(int'(ccTest), mCc[ccSwz[2*i +: 2]])) any = 1;
      tgt = useIndirect ? int'(addrVec[8*addrSel +: 8]) : int'(tgtAddr);
      nPc = mPc + 1;
      if (any) begin
        case (opKind)
          2'd1: nPc = tgt;
          2'd2: if (mStack.size() < 4) begin mStack.push_back(mPc + 1); nPc = tgt; end
                else mOvf = 1;
          2'd3: if (mStack.size() > 0) nPc = mStack.pop_back();
                else begin halt = 1; nPc = mPc; end
          default: ;
        endcase
      end
      if (ccUpdate)
        for (int i = 0; i < 4; i++) mCc[i] = classify(resVec[32*i +: 32]);
      mCnt++;
      if (mCnt == 65536) begin mLim = 1; halt = 1; end
      if (halt) mRun = 0;
      mPc = nPc & 255;
    end
  endtask

  // inputs are set at a falling edge; mask checked before the rising edge,
  // state checked at the following falling edge
  task automatic step(string tag);
    #1;
    chk(tag, "condMask", int'(condMask), expMask());
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkState(tag);
  endtask

  task automatic idleIn();
    start = 0; instValid = 0; opKind = 0; ccUpdate = 0; resVec = '0;
    ccSwz = 8'b11_10_01_00; ccTest = 3'd7; writeMask = 4'hF;
    useIndirect = 0; tgtAddr = 0; addrVec = 32'h33_22_11_00; addrSel = 0;
  endtask

  task automatic inst(int op, int test, int swz, int tgt);
    instValid = 1; opKind = op[1:0]; ccTest = test[2:0]; ccSwz = swz[7:0]; tgtAddr = tgt[7:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idleIn();
    rstN = 0;
    @(negedge clk);
    step("R1");
    rstN = 1;
    step("R1");

    // R12: instruction while idle
    inst(1, 7, 8'hE4, 50); ccUpdate = 1; resVec = {4{32'hBF80_0000}};
    step("R12");
    idleIn();

    // R2: start wins over a branch in the same cycle
    start = 1; inst(1, 7, 8'hE4, 77);
    step("R2");
    idleIn();

    // R3: classification, comp3..0 = NaN, +1, -0, -2
    inst(0, 7, 8'hE4, 0); ccUpdate = 1;
    resVec = {32'h7FC0_0000, 32'h3F80_0000, 32'h8000_0000, 32'hC000_0000};
    step("R3");
    // R3: infinities and +0
    resVec = {32'h7F80_0000, 32'hFF80_0000, 32'h0000_0000, 32'h7F80_0001};
    step("R3");
    // restore LT,EQ,GT,UN on comps 0..3
    resVec = {32'h7FC0_0000, 32'h3F80_0000, 32'h8000_0000, 32'hC000_0000};
    step("R3");

    // R4: no update flag
    ccUpdate = 0; resVec = {4{32'h3F80_0000}};
    step("R4");

    // R5 / R10: every test against identity swizzle, several masks
    for (int t = 0; t < 8; t++) begin
      inst(0, t, 8'hE4, 0); writeMask = 4'hF;
      step("R5");
      writeMask = 4'b1010;
      step("R10");
    end
    writeMask = 4'hF;
    // R10: replicated swizzle of the UN component
    inst(0, 5, 8'hFF, 0); writeMask = 4'b0110;
    step("R10");
    writeMask = 4'hF;

    // R6: conditional branch not taken (GE on LT and UN lanes)
    inst(1, 3, 8'b11_00_11_00, 90);
    step("R6");
    // R6: taken via one passing lane (comp 2 = GT)
    inst(1, 3, 8'b00_10_00_11, 64);
    step("R6");
    // R6: indirect target from component 2
    inst(1, 7, 8'hE4, 0); useIndirect = 1; addrSel = 2; addrVec = 32'h44_90_12_05;
    step("R6");
    useIndirect = 0;

    // same-cycle update and branch: EQ test on comp1 (EQ now), update makes it GT
    inst(1, 2, 8'b01_01_01_01, 20); ccUpdate = 1; resVec = {4{32'h3F80_0000}};
    step("R6");
    ccUpdate = 0;
    inst(1, 2, 8'b01_01_01_01, 99);  // now not taken: codes are GT
    step("R4");

    // R7 / R8: four nested calls, then a fifth overflows
    for (int k = 0; k < 4; k++) begin
      inst(2, 7, 8'hE4, 100 + 10 * k);
      step("R7");
    end
    inst(2, 7, 8'hE4, 200);
    step("R8");
    // a call with a false condition does nothing either
    inst(2, 0, 8'hE4, 222);
    step("R8");
    // R7: unwind four returns
    for (int k = 0; k < 4; k++) begin
      inst(3, 7, 8'hE4, 0);
      step("R7");
    end
    // R9: return with empty stack ends the program
    inst(3, 7, 8'hE4, 0);
    step("R9");
    // R12: ignored while stopped
    inst(1, 7, 8'hE4, 5); ccUpdate = 1; resVec = '0;
    step("R12");
    idleIn();

    // R11: execution budget
    start = 1;
    step("R2");
    idleIn();
    inst(0, 7, 8'hE4, 0);
    for (int n = 0; n < 65536; n++) step("R11");
    inst(1, 7, 8'hE4, 3); ccUpdate = 1; resVec = {4{32'hBF80_0000}};
    step("R12");
    idleIn();
    step("R11");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule